// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device end of a serial flash link, limited to the sequential array read. A host drops chip select and clocks in a read opcode and a 24-bit address. The block then streams bytes from its internal memory, most significant bit first, for as long as the host keeps clocking. Two read opcodes exist. The fast one (0x0B) expects one dummy byte after the address. The slow one (0x03) drives data right after the last address bit. The serial output is an enable/data pair: when the enable is low, the pin is floating.

The memory holds `PAGES` pages. A strap input selects how the address is read. In page mode, a 1056-byte page number and an in-page offset are packed into the address. In linear mode, the address is a plain byte index over `PAGES` x 1024 bytes. In both modes the stream steps from the end of one page straight into the next with no pause, and it returns to byte 0 after the last byte. SCK, chip select and serial input are asynchronous to the system clock and are synchronised inside the block. A write port fills the memory before use.

Top module: `sflash_cread`

## Requirements
- R1: Opcode 0x03 followed by three address bytes makes so_oe go high, with the first data bit on so, before the first SCK rising edge after the address; no dummy byte is taken.
- R2: Opcode 0x0B takes three address bytes and then eight dummy SCK cycles; data starts after the dummy byte.
- R3: With page_mode=1, address bits [23:11] give the page (taken modulo PAGES) and bits [10:0] the offset; the first byte sent is memory index page*PAGE_BYTES+offset.
- R4: With page_mode=0, address bits [22:0] are a linear byte index into a PAGES*LIN_BYTES space; bit 23 is ignored.
- R5: After the last byte of a page, the stream goes on with byte 0 of the following page on the very next byte slot.
- R6: After the last byte of the address space (PAGES*PAGE_BYTES-1 in page mode, PAGES*LIN_BYTES-1 in linear mode), the stream goes on with index 0.
- R7: Chip select going high drops so_oe within three system clocks.
- R8: Chip select going high partway through opcode or address aborts the command, and the next command decodes from a clean state.
- R9: Any opcode other than 0x03 or 0x0B keeps so_oe low until chip select rises.
- R10: In page mode, an offset of PAGE_BYTES or more starts the read at offset 0 of the next page (index 0 from the last page) and sets bad_offset. bad_offset stays set until reset.
- R11: After reset, so_oe and bad_offset are low.
- R12: Bits are sampled on SCK rising edges. Each data byte goes out MSB first, and so changes only after SCK falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| si | input | 1 | Serial data in from the host |
| page_mode | input | 1 | 1: page+offset addressing, 0: linear addressing |
| ld_we | input | 1 | Memory fill write enable |
| ld_addr | input | IW | Memory fill byte index |
| ld_data | input | 8 | Memory fill byte |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (low means floating) |
| bad_offset | output | 1 | Sticky out-of-page offset flag |

## Verification
The bench starts reads two bytes before a page end and two bytes before the array end, in both address modes. A design that adds 1 without the page-sized rollover would leave the memory range or repeat a byte, and the byte comparison would catch it. Offsets past the page size are aimed at both an inner page and the last page, so a clamp that forgets to wrap to page 0 sends the wrong first byte, and a flag that is not sticky shows up on a later read. Dummy-byte handling is compared directly between the two opcodes, where an off-by-eight shows as shifted data. An aborted command and an unknown opcode come before clean reads, so leftover bit counters or an enable driven in the wrong state are caught.

// File: rtl/sflash_cread_pkg.sv
package sflash_cread_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPC,
    S_ADR,
    S_DMY,
    S_LKP,
    S_FET,
    S_PRE,
    S_DAT,
    S_IGN
  } rd_state_e;

  localparam logic [7:0] OP_READ_SLOW = 8'h03;
  localparam logic [7:0] OP_READ_FAST = 8'h0B;

endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_hi,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);

  // one extra stage on sck gives the previous level for edge detection
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] si_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sck};
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
      si_p  <= {si_p[STAGES-2:0], si};
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_hi    = cs_p[STAGES-1];
  assign si_s     = si_p[STAGES-1];

endmodule

// File: rtl/sflash_addr_map.sv
module sflash_addr_map #(
  parameter int unsigned PAGES      = 2,
  parameter int unsigned PAGE_BYTES = 1056,
  parameter int unsigned LIN_BYTES  = 1024,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned OFF_BITS   = 11,
  parameter int unsigned LIN_BITS   = 23,
  parameter int unsigned IW         = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_mode,
  output logic [IW-1:0]     start_idx,
  output logic              off_bad
);

  localparam int unsigned LIN_TOTAL = PAGES * LIN_BYTES;

  int unsigned pg_u, off_u, pm_u, lin_u, idx_u;

  always_comb begin
    pg_u    = 32'(addr[ADDR_W-1:OFF_BITS]);
    off_u   = 32'(addr[OFF_BITS-1:0]);
    pm_u    = pg_u % PAGES;
    lin_u   = 32'(addr[LIN_BITS-1:0]) % LIN_TOTAL;
    off_bad = 1'b0;
    if (page_mode) begin
      if (off_u >= PAGE_BYTES) begin
        // clamp to start of the following page
        off_bad = 1'b1;
        idx_u   = (pm_u == PAGES - 1) ? 32'd0 : (pm_u + 1) * PAGE_BYTES;
      end else begin
        idx_u = pm_u * PAGE_BYTES + off_u;
      end
    end else begin
      idx_u = lin_u;
    end
    start_idx = IW'(idx_u);
  end

endmodule

// File: rtl/sflash_mem.sv
module sflash_mem #(
  parameter int unsigned DEPTH = 2112,
  parameter int unsigned IW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end

endmodule

// File: rtl/sflash_cread.sv
module sflash_cread
  import sflash_cread_pkg::*;
#(
  parameter int unsigned PAGES      = 2,
  parameter int unsigned PAGE_BYTES = 1056,
  parameter int unsigned LIN_BYTES  = 1024,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned OFF_BITS   = 11,
  parameter int unsigned LIN_BITS   = 23,
  parameter int unsigned SYNC       = 2,
  localparam int unsigned IW        = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          page_mode,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output logic          so,
  output logic          so_oe,
  output logic          bad_offset
);

  localparam int unsigned DEPTH     = PAGES * PAGE_BYTES;
  localparam int unsigned LIN_TOTAL = PAGES * LIN_BYTES;
  localparam int unsigned CW        = $clog2(ADDR_W);

  logic cs_hi, sck_rise, sck_fall, si_s;

  sflash_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_hi(cs_hi), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  rd_state_e         st;
  logic [CW-1:0]     cnt;
  logic [7:0]        opc;
  logic [7:0]        op_nx;
  logic [ADDR_W-1:0] adr;
  logic [IW-1:0]     ptr, nxt_idx, last_idx, start_idx;
  logic              mode_q, off_bad, seen_rise, oe, bad;
  logic [2:0]        bit_i;
  logic [7:0]        sh, rdata;

  assign op_nx = {opc[6:0], si_s};

  sflash_addr_map #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .LIN_BYTES(LIN_BYTES),
    .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .LIN_BITS(LIN_BITS), .IW(IW)
  ) u_map (
    .addr(adr), .page_mode(page_mode), .start_idx(start_idx), .off_bad(off_bad)
  );

  sflash_mem #(.DEPTH(DEPTH), .IW(IW)) u_mem (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr(ptr), .rdata(rdata)
  );

  assign last_idx = mode_q ? IW'(DEPTH - 1) : IW'(LIN_TOTAL - 1);
  assign nxt_idx  = (ptr == last_idx) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      opc       <= '0;
      adr       <= '0;
      ptr       <= '0;
      mode_q    <= 1'b1;
      seen_rise <= 1'b0;
      bit_i     <= '0;
      sh        <= '0;
      oe        <= 1'b0;
      bad       <= 1'b0;
    end else if (cs_hi) begin
      st        <= S_IDLE;
      oe        <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_OPC;
          cnt <= '0;
          opc <= '0;
        end
        S_OPC: if (sck_rise) begin
          opc <= op_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            st  <= (op_nx == OP_READ_SLOW || op_nx == OP_READ_FAST) ? S_ADR : S_IGN;
          end
        end
        S_ADR: if (sck_rise) begin
          adr <= {adr[ADDR_W-2:0], si_s};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ADDR_W - 1)) begin
            cnt <= '0;
            st  <= (opc == OP_READ_FAST) ? S_DMY : S_LKP;
          end
        end
        S_DMY: if (sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7)) st <= S_LKP;
        end
        S_LKP: begin
          ptr    <= start_idx;
          mode_q <= page_mode;
          if (off_bad) bad <= 1'b1;
          st     <= S_FET;
        end
        S_FET: st <= S_PRE;
        S_PRE: begin
          sh        <= rdata;
          oe        <= 1'b1;
          ptr       <= nxt_idx;
          seen_rise <= 1'b0;
          bit_i     <= '0;
          st        <= S_DAT;
        end
        S_DAT: begin
          if (sck_rise) begin
            seen_rise <= 1'b1;
          end else if (sck_fall && seen_rise) begin
            seen_rise <= 1'b0;
            bit_i     <= bit_i + 1'b1;
            if (bit_i == 3'd7) begin
              sh  <= rdata;
              ptr <= nxt_idx;
            end else begin
              sh <= {sh[6:0], 1'b0};
            end
          end
        end
        S_IGN: st <= S_IGN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign so         = oe & sh[7];
  assign so_oe      = oe;
  assign bad_offset = bad;

  // R7: chip select release silences the output on the next clock
  p_cs_release_r7: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !so_oe);

  // R9: an unrecognised opcode never enables the output
  p_ignore_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_IGN) |-> !so_oe);

  // R10: the offset error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    bad_offset |=> bad_offset);

  // R6: the read pointer stays inside the active address space
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_DAT) |-> (ptr <= last_idx));

  // R12: output bit moves only after a detected falling SCK edge
  p_bit_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (st == S_DAT && $past(st) == S_DAT && !$past(sck_fall)) |-> $stable(so));

  // R1: output enable only during the data phase
  p_oe_data_only_r1: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (st == S_DAT));

endmodule

// File: tb/sflash_cread_test.sv
module sflash_cread_test;

  localparam int unsigned PAGES      = 2;
  localparam int unsigned PAGE_BYTES = 1056;
  localparam int unsigned LIN_BYTES  = 1024;
  localparam int unsigned DEPTH      = PAGES * PAGE_BYTES;
  localparam int unsigned LIN_TOTAL  = PAGES * LIN_BYTES;
  localparam int unsigned IW         = $clog2(DEPTH);
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, page_mode = 1'b1;
  logic ld_we = 1'b0;
  logic [IW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic so, so_oe, bad_offset;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      cur_req = "R1";
  bit         data_phase = 0;
  bit         quiet_phase = 0;
  logic [7:0] mon_sr = '0;
  int         mon_n = 0;

  always #4 clk = ~clk;

  sflash_cread uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .page_mode(page_mode), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .so(so), .so_oe(so_oe), .bad_offset(bad_offset)
  );

  function automatic logic [7:0] pat(int unsigned i);
    return 8'((i * 37 + (i >> 5)) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: collects bits at SCK rising edges and pops the scoreboard
  always @(posedge sck) begin
    if (data_phase) begin
      check(so_oe === 1'b1, cur_req, int'(so_oe), 1);
      mon_sr = {mon_sr[6:0], so};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) check(1'b0, cur_req, int'(mon_sr), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_sr === e, {cur_req, "/R12"}, int'(mon_sr), int'(e));
        end
      end
    end
    if (quiet_phase) check(so_oe === 1'b0, "R9", int'(so_oe), 0);
  end

  task automatic tick_bit(input logic b);
    @(negedge clk);
    si = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tick_bit(b[i]);
  endtask

  task automatic begin_cmd(input logic [7:0] op, input logic [23:0] a);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    send_byte(op);
    send_byte(a[23:16]);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    if (op == 8'h0B) send_byte(8'h00);
  endtask

  task automatic release_cs();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check(so_oe === 1'b0, "R7", int'(so_oe), 0);
  endtask

  // driver: pushes expected bytes then clocks the data phase
  task automatic do_read(input string req, input logic [7:0] op, input logic [23:0] a,
                         input int unsigned first, input int unsigned top, input int n);
    int unsigned idx;
    cur_req = req;
    idx = first;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(pat(idx));
      idx = (idx == top - 1) ? 0 : idx + 1;
    end
    begin_cmd(op, a);
    data_phase = 1;
    for (int k = 0; k < n * 8; k++) tick_bit(1'b0);
    repeat (2) @(negedge clk);
    data_phase = 0;
    check(so_oe === 1'b1, req, int'(so_oe), 1);
    release_cs();
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  function automatic logic [23:0] pa(int unsigned pg, int unsigned off);
    return {13'(pg), 11'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(so_oe === 1'b0, "R11", int'(so_oe), 0);
    rst = 1'b0;
    for (int unsigned i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = IW'(i); ld_data = pat(i);
    end
    @(negedge clk);
    ld_we = 1'b0;
    repeat (4) @(negedge clk);
    check(so_oe === 1'b0, "R11", int'(so_oe), 0);
    check(bad_offset === 1'b0, "R11", int'(bad_offset), 0);

    // R8: abort after opcode and one address byte
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    send_byte(8'h03);
    send_byte(8'h00);
    tick_bit(1'b1);
    release_cs();

    // R9: unknown opcode keeps the output off
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    send_byte(8'h9F);
    quiet_phase = 1;
    for (int k = 0; k < 16; k++) tick_bit(1'b1);
    quiet_phase = 0;
    release_cs();

    // R1, R3, R8: slow read, page 0 offset 5
    do_read("R1", 8'h03, pa(0, 5), 5, DEPTH, 4);
    // R2, R3: fast read, page 1 offset 100
    do_read("R2", 8'h0B, pa(1, 100), PAGE_BYTES + 100, DEPTH, 3);
    do_read("R3", 8'h03, pa(3, 7), PAGE_BYTES + 7, DEPTH, 2);
    // R5: page crossing
    do_read("R5", 8'h03, pa(0, PAGE_BYTES - 2), PAGE_BYTES - 2, DEPTH, 4);
    // R6: array wrap in page mode
    do_read("R6", 8'h0B, pa(1, PAGE_BYTES - 2), DEPTH - 2, DEPTH, 4);
    check(bad_offset === 1'b0, "R10", int'(bad_offset), 0);

    // R4: linear mode, bit 23 ignored
    page_mode = 1'b0;
    do_read("R4", 8'h03, 24'h800000 | 24'd1500, 1500, LIN_TOTAL, 3);
    do_read("R6", 8'h0B, 24'd2046, LIN_TOTAL - 2, LIN_TOTAL, 4);
    check(bad_offset === 1'b0, "R10", int'(bad_offset), 0);
    page_mode = 1'b1;

    // R10: offset past page end
    do_read("R10", 8'h03, pa(0, PAGE_BYTES + 4), PAGE_BYTES, DEPTH, 2);
    check(bad_offset === 1'b1, "R10", int'(bad_offset), 1);
    do_read("R10", 8'h0B, pa(1, 2000), 0, DEPTH, 2);
    check(bad_offset === 1'b1, "R10", int'(bad_offset), 1);
    do_read("R10", 8'h03, pa(0, 9), 9, DEPTH, 1);
    check(bad_offset === 1'b1, "R10", int'(bad_offset), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule